// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block gathers 32 interrupt inputs and drives two interrupt request lines and a wakeup line. Software programs it through a small register port. Each control vector has one bit per source, and each vector has two write addresses. Writing to the set address turns on the bits written as 1. Writing to the clear address turns off the bits written as 1. Bits written as 0 keep their value, so no read-modify-write is ever needed.

The raw inputs pass through a two-flop synchronizer first. Three configuration planes then pick the trigger for each source: active-high level, active-low level, or off. A source-select bit gates the source. An assignment bit steers the source to request line 0 or request line 1. The mask gates the requests. A separate wakeup vector decides which active sources raise the wakeup output, whatever the mask holds. Two edge-pending vectors record the rising and falling edges of the selected sources. Software clears them by writing ones.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset, every control vector, both edge-pending vectors and both status registers read 0, and irq_req0, irq_req1 and wake_out are low.
- R2: There are seven control vector pairs at word addresses mask 0/1, wakeup 2/3, source select 4/5, assignment 6/7, plane0 8/9, plane1 10/11 and plane2 12/13. In each pair the even address is set and the odd address is clear. A write to the set address sets exactly the bits written as 1 and leaves the other bits unchanged. A read of either address of a pair returns that vector.
- R3: A write to a clear address clears exactly the bits written as 1 and leaves the other bits unchanged.
- R4: A source whose code {plane2, plane1, plane0} is 3'b101 is active while its synchronized input is high.
- R5: A source whose code is 3'b110 is active while its synchronized input is low.
- R6: A source with any other code, including 3'b000, is never active.
- R7: A source whose source-select bit is 0 is never active and records no edges.
- R8: irq_req0 is the OR of (active AND mask AND assignment=1). irq_req1 is the OR of (active AND mask AND assignment=0). A source with its mask bit at 0 requests on neither line.
- R9: Address 16 reads the per-source status for line 0. Address 17 reads the status for line 1. Address 18 reads the mask vector.
- R10: Address 14 reads the rising-edge pending bits and address 15 reads the falling-edge pending bits of the synchronized inputs of selected sources. Writing a 1 to either address clears that bit. If a new edge arrives in the same cycle as the clear, the edge wins.
- R11: wake_out is high when some active source has its wakeup bit at 1. The mask has no effect on it.
- R12: A change on irq_in reaches the status registers, the request lines, wake_out and the pending bits on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Word address for a write or a read |
| reg_wdata | input | 32 | Write data |
| irq_in | input | 32 | Raw interrupt inputs, one per source |
| rd_data | output | 32 | Read data for reg_addr (combinational) |
| irq_req0 | output | 1 | Request line 0 |
| irq_req1 | output | 1 | Request line 1 |
| wake_out | output | 1 | Wakeup output |

## Verification
Two functions can act on the same pending bit in one cycle: software can clear an edge-pending bit in the same cycle that a new edge sets it. The bench forces this case. It drives a new rising edge on one source and times a write-one-to-clear to land on the exact edge where that pending bit is captured. The same write also clears a second bit that is already pending and sees no new edge. The bench then expects the new edge to survive and the old bit to be cleared. All other expected values, including a sweep of every trigger code with both input levels and both routings, are computed arithmetically in the bench.

// File: rtl/irq_sc_pkg.sv
// Package: shared address map and trigger codes for the set/clear interrupt
// controller. Assumes word addressing on the register port.
package irq_sc_pkg;
    localparam int NUM_PAIRS = 7;   // control vectors with set/clear addresses
    localparam int P_MASK    = 0;
    localparam int P_WAKE    = 1;
    localparam int P_SRC     = 2;
    localparam int P_ASG     = 3;
    localparam int P_CFG0    = 4;
    localparam int P_CFG1    = 5;
    localparam int P_CFG2    = 6;
    localparam int A_RISE    = 14;
    localparam int A_FALL    = 15;
    localparam int A_STAT0   = 16;
    localparam int A_STAT1   = 17;
    localparam int A_MASK_RD = 18;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'b000,
        TRG_HIGH = 3'b101,
        TRG_LOW  = 3'b110
    } trig_e;
endpackage

// File: rtl/irq_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous inputs.
// Assumes the inputs are quasi-static for each bit. Resets to 0.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two-stage capture of the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/irq_setclr_regs.sv
// Module: bank of control vectors. Each vector has a set address (2p) and a
// clear address (2p+1). Only one address is written per cycle, so set and
// clear never meet on the same vector.
module irq_setclr_regs #(
    parameter int W  = 32,
    parameter int NP = 7,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [W-1:0]         wdata,
    output logic [NP-1:0][W-1:0] vec_q
);
    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam logic [AW-1:0] SET_A = AW'(2 * p);
        localparam logic [AW-1:0] CLR_A = AW'(2 * p + 1);

        // Apply set or clear writes to one vector.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[p] <= '0;
            end else if (wr_en && addr == SET_A) begin
                vec_q[p] <= vec_q[p] | wdata;
            end else if (wr_en && addr == CLR_A) begin
                vec_q[p] <= vec_q[p] & ~wdata;
            end
        end
    end
endmodule

// File: rtl/irq_trig_decode.sv
// Module: per-source trigger decode. It turns a synchronized level, a
// three-plane code and a source-select bit into an active flag. Codes that
// are not listed in the package count as off.
module irq_trig_decode
    import irq_sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] cfg0,
    input  logic [W-1:0] cfg1,
    input  logic [W-1:0] cfg2,
    input  logic [W-1:0] src_sel,
    output logic [W-1:0] active
);
    for (genvar i = 0; i < W; i++) begin : g_src
        trig_e code;
        assign code = trig_e'({cfg2[i], cfg1[i], cfg0[i]});

        // Decode the polarity for one source.
        always_comb begin
            case (code)
                TRG_HIGH: active[i] = src_sel[i] & lvl[i];
                TRG_LOW:  active[i] = src_sel[i] & ~lvl[i];
                default:  active[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_edge_pend.sv
// Module: rising and falling edge pending vectors, each with its own
// write-one-to-clear address. A new edge wins over a clear in the same cycle.
// Assumes lvl is already synchronized.
module irq_edge_pend
    import irq_sc_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  lvl,
    input  logic [W-1:0]  src_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rise_q,
    output logic [W-1:0]  fall_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise_ev, fall_ev, rise_clr, fall_clr;

    assign rise_ev  = lvl & ~prev_q & src_sel;
    assign fall_ev  = ~lvl & prev_q & src_sel;
    assign rise_clr = (wr_en && addr == AW'(A_RISE)) ? wdata : '0;
    assign fall_clr = (wr_en && addr == AW'(A_FALL)) ? wdata : '0;

    // Remember the last level and accumulate the edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            prev_q <= lvl;
            rise_q <= (rise_q & ~rise_clr) | rise_ev;
            fall_q <= (fall_q & ~fall_clr) | fall_ev;
        end
    end
endmodule

// File: rtl/irq_setclr_ctrl.sv
// Module: top of the set/clear interrupt controller. It holds the control
// bank, the synchronizer, the trigger decode and the edge pending logic, and
// registers the per-line status and the wakeup. Reads are combinational.
module irq_setclr_ctrl
    import irq_sc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    input  logic [NSRC-1:0] irq_in,
    output logic [NSRC-1:0] rd_data,
    output logic            irq_req0,
    output logic            irq_req1,
    output logic            wake_out
);
    logic [NUM_PAIRS-1:0][NSRC-1:0] vec_q;
    logic [NSRC-1:0] mask_q, wake_q, asg_q;
    logic [NSRC-1:0] lvl_s, active, rise_q, fall_q;
    logic [NSRC-1:0] stat0_q, stat1_q;
    logic            wake_r;

    irq_setclr_regs #(.W(NSRC), .NP(NUM_PAIRS), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .vec_q(vec_q)
    );

    irq_sync #(.W(NSRC)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(irq_in), .d_out(lvl_s)
    );

    irq_trig_decode #(.W(NSRC)) dec_i (
        .lvl(lvl_s), .cfg0(vec_q[P_CFG0]), .cfg1(vec_q[P_CFG1]),
        .cfg2(vec_q[P_CFG2]), .src_sel(vec_q[P_SRC]), .active(active)
    );

    irq_edge_pend #(.W(NSRC), .AW(AW)) pend_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .src_sel(vec_q[P_SRC]),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rise_q(rise_q), .fall_q(fall_q)
    );

    assign mask_q = vec_q[P_MASK];
    assign wake_q = vec_q[P_WAKE];
    assign asg_q  = vec_q[P_ASG];

    // Register the masked per-line status and the wakeup flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat0_q <= '0;
            stat1_q <= '0;
            wake_r  <= 1'b0;
        end else begin
            stat0_q <= active & mask_q & asg_q;
            stat1_q <= active & mask_q & ~asg_q;
            wake_r  <= |(active & wake_q);
        end
    end

    assign irq_req0 = |stat0_q;
    assign irq_req1 = |stat1_q;
    assign wake_out = wake_r;

    // Read multiplexer over the vectors, pending and status registers.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (reg_addr == AW'(2 * p) || reg_addr == AW'(2 * p + 1)) begin
                rd_data = vec_q[p];
            end
        end
        if (reg_addr == AW'(A_RISE))    rd_data = rise_q;
        if (reg_addr == AW'(A_FALL))    rd_data = fall_q;
        if (reg_addr == AW'(A_STAT0))   rd_data = stat0_q;
        if (reg_addr == AW'(A_STAT1))   rd_data = stat1_q;
        if (reg_addr == AW'(A_MASK_RD)) rd_data = mask_q;
    end
endmodule

// File: rtl/irq_setclr_ctrl_chk.sv
// Module: property checker for irq_setclr_ctrl, attached by bind. It watches
// the mask, assignment and wakeup vectors against the outputs.
module irq_setclr_ctrl_chk #(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [NSRC-1:0] reg_wdata,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] asg_q,
    input logic [NSRC-1:0] wake_q,
    input logic            irq_req0,
    input logic            irq_req1,
    input logic            wake_out
);
    a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(0)) |=>
        ((mask_q & $past(reg_wdata)) == $past(reg_wdata)) &&
        ((mask_q & ~$past(reg_wdata)) == ($past(mask_q) & ~$past(reg_wdata))));

    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(1)) |=>
        ((mask_q & $past(reg_wdata)) == '0) &&
        ((mask_q & ~$past(reg_wdata)) == ($past(mask_q) & ~$past(reg_wdata))));

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == '0) |-> (!irq_req0 && !irq_req1));

    a_r8_all_to_req0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(asg_q) == '1) |-> !irq_req1);

    a_r11_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wake_q) == '0) |-> !wake_out);
endmodule

bind irq_setclr_ctrl irq_setclr_ctrl_chk #(.NSRC(NSRC), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mask_q(mask_q), .asg_q(asg_q), .wake_q(wake_q),
    .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
);

// File: tb/irq_setclr_ctrl_tb_top.sv
module irq_setclr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, irq_in, rd_data;
    logic        irq_req0, irq_req1, wake_out;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_setclr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_in(irq_in), .rd_data(rd_data),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_out(wake_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 v = rd_data;
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic act_of(int code, logic lvl);
        if (code == 5) return lvl;
        if (code == 6) return ~lvl;
        return 1'b0;
    endfunction

    task automatic clear_all();
        for (int a = 1; a < 14; a += 2) wr(a, '1);
        wr(14, '1); wr(15, '1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m[7], c0, c1, c2, asg, lvl, act, exp0, exp1, src;
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; irq_in = 0;
        wait_n(3);
        rst_n = 1;

        // R1: reset values on every readable address and on outputs
        for (int a = 0; a < 19; a++) begin
            rd(a, v); chk($sformatf("R1 addr %0d", a), v, 0);
        end
        chk("R1 outputs", {29'b0, irq_req0, irq_req1, wake_out}, 0);

        // R2/R3: set/clear sweep over every control address
        for (int p = 0; p < 7; p++) m[p] = 0;
        for (int r = 0; r < 3; r++) begin
            for (int a = 0; a < 14; a++) begin
                logic [31:0] d;
                d = 32'hA5C3_0F96 ^ (32'(a) * 32'h0101_0101) ^ (32'(r) * 32'h3C3C_1111);
                wr(a, d);
                if (a % 2 == 0) m[a/2] = m[a/2] | d; else m[a/2] = m[a/2] & ~d;
                rd(a, v);     chk($sformatf("%s addr %0d", (a % 2 == 0) ? "R2" : "R3", a), v, m[a/2]);
                rd(a ^ 1, v); chk($sformatf("R2 pair addr %0d", a ^ 1), v, m[a/2]);
                if (a / 2 == 0) begin
                    rd(18, v); chk("R9 mask read", v, m[0]);
                end
            end
        end
        clear_all();

        // R4/R5/R6/R8/R9: all 8 codes x both levels x both routes at once
        c0 = 0; c1 = 0; c2 = 0; asg = 0; lvl = 0;
        for (int i = 0; i < 32; i++) begin
            c0[i] = (i >> 2) & 1; c1[i] = (i >> 3) & 1; c2[i] = (i >> 4) & 1;
            lvl[i] = (i >> 1) & 1; asg[i] = i & 1;
        end
        wr(4, '1); wr(0, '1); wr(8, c0); wr(10, c1); wr(12, c2); wr(6, asg);
        for (int ph = 0; ph < 2; ph++) begin
            logic [31:0] drv;
            drv = (ph == 0) ? lvl : ~lvl;
            @(negedge clk); irq_in = drv;
            wait_n(3);
            for (int i = 0; i < 32; i++) act[i] = act_of(i >> 2, drv[i]);
            exp0 = act & asg; exp1 = act & ~asg;
            chk("R4 R5 R6 req0 pin", {31'b0, irq_req0}, {31'b0, |exp0});
            chk("R8 req1 pin", {31'b0, irq_req1}, {31'b0, |exp1});
            rd(16, v); chk($sformatf("R4 R5 R9 stat0 ph%0d", ph), v, exp0);
            rd(17, v); chk($sformatf("R6 R9 stat1 ph%0d", ph), v, exp1);
        end
        // R10: 0->lvl then lvl->~lvl gives a rise on every bit, a fall on lvl bits
        rd(14, v); chk("R10 rise pend", v, '1);
        rd(15, v); chk("R10 fall pend", v, lvl);
        wr(14, 32'h0000_FFFF);
        rd(14, v); chk("R10 rise w1c", v, 32'hFFFF_0000);

        // R7: deselect the lower half
        wr(5, 32'h0000_FFFF);
        src = 32'hFFFF_0000;
        for (int i = 0; i < 32; i++) act[i] = act_of(i >> 2, ~lvl[i]) & src[i];
        wait_n(1);
        rd(16, v); chk("R7 stat0 deselect", v, act & asg);
        rd(17, v); chk("R7 stat1 deselect", v, act & ~asg);

        // R11: wakeup ignores the mask
        wr(2, 32'hFFFF_0000);
        wr(1, '1);
        wait_n(1);
        chk("R11 masked reqs low", {30'b0, irq_req0, irq_req1}, 0);
        chk("R11 wake with mask off", {31'b0, wake_out}, {31'b0, |(act & 32'hFFFF_0000)});
        wr(3, '1); wr(2, ~act);
        wait_n(1);
        chk("R11 wake on inactive only", {31'b0, wake_out}, 0);

        // R12: latency of exactly three edges
        clear_all();
        @(negedge clk); irq_in = 0;
        wait_n(3);
        wr(4, 32'h38); wr(0, 32'h08); wr(8, 32'h08); wr(12, 32'h08); wr(6, 32'h08);
        wr(14, '1);
        @(negedge clk); irq_in[3] = 1'b1;
        wait_n(2);
        chk("R12 req0 not before third edge", {31'b0, irq_req0}, 0);
        wait_n(1);
        chk("R12 req0 at third edge", {31'b0, irq_req0}, 1);
        rd(14, v); chk("R10 R12 rise bit3", v, 32'h08);

        // R10: clear and new edge in the same cycle; the edge wins
        wr(14, '1);
        @(negedge clk); irq_in[4] = 1'b1;
        wait_n(3);
        rd(14, v); chk("R10 bit4 pending", v, 32'h10);
        @(negedge clk); irq_in[5] = 1'b1;
        wait_n(2);
        reg_wr = 1'b1; reg_addr = 5'd14; reg_wdata = 32'h30;
        @(negedge clk); reg_wr = 1'b0;
        rd(14, v); chk("R10 set wins over clear", v, 32'h20);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule